// File: doc/BRIEF.md
# DMA Channel Event Status and Interrupt Unit

This block gathers completion and fault events from a set of DMA channel engines. Each engine raises single-cycle pulses for four kinds of event: full completion, halfway point, error and abort. The unit holds each event in a sticky status bit until software clears it by writing a one. A per-channel set of inhibit bits decides which stored events reach the single interrupt line. The interrupt is raised while any stored event is not inhibited.

The same register port also holds per-channel control. This covers a run bit, a repeat bit and the four inhibit bits. A read-only vector gathers all run bits in one word. A write-only register requests abort on every channel named in the written bitmask. A global clear bit returns every channel to idle. For each channel, a read-only summary word packs the stored events into one flag set. That word reports "busy" only when no event is stored.

Register map (byte addresses): 0x00 global control (bit 0 = global clear, reads 0); 0x04 run vector; 0x08 abort request (write-only, reads 0); 0x0C completion status; 0x10 halfway status; 0x14 error status; 0x18 abort status; 0x40 + 4*ch channel control; 0x80 + 4*ch channel summary.

Top module: `chan_event_ctl`

## Requirements
- R1: After reset, every status register, every run bit, every repeat bit, every inhibit bit, the abort request output and `irq` are all zero.
- R2: An event pulse on channel c sets bit c of that event's status register: completion at 0x0C, halfway at 0x10, error at 0x14, abort at 0x18. The new value can be read on the cycle after the pulse.
- R3: Writing a status register clears each bit written as 1. Bits written as 0 keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: `irq` is high exactly when some channel has a stored event whose inhibit bit is 0. Channel control bit 2 inhibits error, bit 3 abort, bit 4 completion and bit 5 halfway. An inhibited event is still stored.
- R6: The summary word for channel c is built as follows: error = 2, abort = 4, completion = 8, halfway = 16, ORed together. If none of these is stored it reads 1 (busy).
- R7: Writing a bitmask to 0x08 drives `abort_req` to that bitmask for exactly one cycle, starting on the clock edge of the write.
- R8: Channel control bit 0 is the run bit and bit 1 the repeat bit. The run vector at 0x04 and `ch_enable` mirror the run bits. A run bit clears itself on an error or abort pulse, and on a completion pulse unless the repeat bit is set. A same-cycle pulse wins over a write.
- R9: Writing 1 to bit 0 of 0x00 clears every run bit and every status bit, even against same-cycle event pulses. Inhibit and repeat bits keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| ev_tc | input | NCH | Completion pulse per channel |
| ev_half | input | NCH | Halfway pulse per channel |
| ev_err | input | NCH | Error pulse per channel |
| ev_abt | input | NCH | Abort-done pulse per channel |
| ch_enable | output | NCH | Run bit per channel |
| abort_req | output | NCH | One-cycle abort request per channel |
| irq | output | 1 | Combined interrupt |

## Verification
Three pairs of functions can fall in one cycle. A clearing write can meet an event pulse on the same status bit. A run-bit write can meet a self-clearing event. The global clear can meet fresh event pulses. The bench drives each pair on one clock edge. In the first case it also clears a neighbouring bit in the same write, so that clearing is shown to still work. Each collision is judged by reading the status, run vector and summary registers the cycle after, against values the bench builds from the event priority rules.

// File: rtl/chan_event_pkg.sv
package chan_event_pkg;
  localparam int REG_AW = 8;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFF_GCTRL = 8'h00;
  localparam logic [REG_AW-1:0] OFF_RUNV  = 8'h04;
  localparam logic [REG_AW-1:0] OFF_ABORT = 8'h08;
  localparam logic [REG_AW-1:0] OFF_TC    = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_HALF  = 8'h10;
  localparam logic [REG_AW-1:0] OFF_ERR   = 8'h14;
  localparam logic [REG_AW-1:0] OFF_ABT   = 8'h18;
  localparam logic [REG_AW-1:0] OFF_CFG0  = 8'h40;
  localparam logic [REG_AW-1:0] OFF_SUM0  = 8'h80;

  typedef struct packed {
    logic inh_half;
    logic inh_tc;
    logic inh_abt;
    logic inh_err;
    logic repeat_on;
    logic run;
  } chan_cfg_t;

  function automatic logic [4:0] status_flags(input logic tc, input logic half,
                                              input logic err, input logic abt);
    logic [4:0] f;
    f = {half, tc, abt, err, 1'b0};
    if (f == 5'd0) f = 5'd1;
    return f;
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ev,
  input  logic           clr_we,
  input  logic [NCH-1:0] clr_bits,
  input  logic           gclr,
  output logic [NCH-1:0] sts
);
  logic [NCH-1:0] sts_q;
  logic [NCH-1:0] sts_d;
  logic           sts_en;

  always_comb begin
    sts_d = sts_q;
    if (clr_we) sts_d = sts_d & ~clr_bits;
    sts_d = sts_d | ev;          // a fresh event beats a same-cycle clear
    if (gclr) sts_d = '0;        // global clear beats everything
    sts_en = clr_we | (|ev) | gclr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign sts = sts_q;
endmodule

// File: rtl/chan_cfg_slot.sv
module chan_cfg_slot
  import chan_event_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [5:0] wdata,
  input  logic      ev_tc,
  input  logic      ev_err,
  input  logic      ev_abt,
  input  logic      gclr,
  output chan_cfg_t cfg
);
  chan_cfg_t cfg_q;
  chan_cfg_t cfg_d;
  logic      stop_ev;
  logic      cfg_en;

  always_comb begin
    cfg_d   = cfg_q;
    stop_ev = ev_err | ev_abt | (ev_tc & ~cfg_q.repeat_on);
    if (wr) cfg_d = chan_cfg_t'(wdata);
    if (stop_ev | gclr) cfg_d.run = 1'b0;
    cfg_en  = wr | stop_ev | gclr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] tc_sts,
  input  logic [NCH-1:0] half_sts,
  input  logic [NCH-1:0] err_sts,
  input  logic [NCH-1:0] abt_sts,
  input  logic [NCH-1:0] inh_tc,
  input  logic [NCH-1:0] inh_half,
  input  logic [NCH-1:0] inh_err,
  input  logic [NCH-1:0] inh_abt,
  output logic           irq
);
  logic [NCH-1:0] live;

  always_comb begin
    live = (tc_sts & ~inh_tc) | (half_sts & ~inh_half) |
           (err_sts & ~inh_err) | (abt_sts & ~inh_abt);
    irq  = |live;
  end
endmodule

// File: rtl/chan_event_ctl.sv
module chan_event_ctl
  import chan_event_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  input  logic [NCH-1:0]      ev_tc,
  input  logic [NCH-1:0]      ev_half,
  input  logic [NCH-1:0]      ev_err,
  input  logic [NCH-1:0]      ev_abt,
  output logic [NCH-1:0]      ch_enable,
  output logic [NCH-1:0]      abort_req,
  output logic                irq
);
  localparam int SLOT_W = $bits(chan_cfg_t);

  logic            rst_sync_n;
  logic            gclr;
  logic [NCH-1:0]  wbits;
  logic [NCH-1:0]  tc_sts, half_sts, err_sts, abt_sts;
  logic [NCH-1:0]  inh_tc, inh_half, inh_err, inh_abt;
  logic [NCH-1:0]  abort_d;
  chan_cfg_t       cfg [NCH];
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata;
  assign wbits        = reg_wdata[NCH-1:0];
  assign gclr         = reg_we && (reg_addr == OFF_GCTRL) && reg_wdata[0];

  rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_sync_n));

  evt_sticky_bank #(.NCH(NCH)) u_tc (
    .clk(clk), .rst_n(rst_sync_n), .ev(ev_tc),
    .clr_we(reg_we && reg_addr == OFF_TC), .clr_bits(wbits), .gclr(gclr), .sts(tc_sts));
  evt_sticky_bank #(.NCH(NCH)) u_half (
    .clk(clk), .rst_n(rst_sync_n), .ev(ev_half),
    .clr_we(reg_we && reg_addr == OFF_HALF), .clr_bits(wbits), .gclr(gclr), .sts(half_sts));
  evt_sticky_bank #(.NCH(NCH)) u_err (
    .clk(clk), .rst_n(rst_sync_n), .ev(ev_err),
    .clr_we(reg_we && reg_addr == OFF_ERR), .clr_bits(wbits), .gclr(gclr), .sts(err_sts));
  evt_sticky_bank #(.NCH(NCH)) u_abt (
    .clk(clk), .rst_n(rst_sync_n), .ev(ev_abt),
    .clr_we(reg_we && reg_addr == OFF_ABT), .clr_bits(wbits), .gclr(gclr), .sts(abt_sts));

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic slot_wr;
    assign slot_wr = reg_we && (reg_addr == REG_AW'(OFF_CFG0 + 4 * c));

    chan_cfg_slot u_slot (
      .clk(clk), .rst_n(rst_sync_n), .wr(slot_wr), .wdata(reg_wdata[SLOT_W-1:0]),
      .ev_tc(ev_tc[c]), .ev_err(ev_err[c]), .ev_abt(ev_abt[c]), .gclr(gclr),
      .cfg(cfg[c]));

    assign ch_enable[c] = cfg[c].run;
    assign inh_tc[c]    = cfg[c].inh_tc;
    assign inh_half[c]  = cfg[c].inh_half;
    assign inh_err[c]   = cfg[c].inh_err;
    assign inh_abt[c]   = cfg[c].inh_abt;
  end

  irq_merge #(.NCH(NCH)) u_irq (
    .tc_sts(tc_sts), .half_sts(half_sts), .err_sts(err_sts), .abt_sts(abt_sts),
    .inh_tc(inh_tc), .inh_half(inh_half), .inh_err(inh_err), .inh_abt(inh_abt),
    .irq(irq));

  // abort request: one-cycle pulse registered from the write
  always_comb begin
    abort_d = '0;
    if (reg_we && reg_addr == OFF_ABORT && !gclr) abort_d = wbits;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) abort_req <= '0;
    else             abort_req <= abort_d;
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_RUNV: reg_rdata = REG_DW'(ch_enable);
      OFF_TC:   reg_rdata = REG_DW'(tc_sts);
      OFF_HALF: reg_rdata = REG_DW'(half_sts);
      OFF_ERR:  reg_rdata = REG_DW'(err_sts);
      OFF_ABT:  reg_rdata = REG_DW'(abt_sts);
      default:  ;
    endcase
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == REG_AW'(OFF_CFG0 + 4 * c)) reg_rdata = REG_DW'(cfg[c]);
      if (reg_addr == REG_AW'(OFF_SUM0 + 4 * c))
        reg_rdata = REG_DW'(status_flags(tc_sts[c], half_sts[c], err_sts[c], abt_sts[c]));
    end
  end
endmodule

// File: rtl/chan_event_chk.sv
module chan_event_chk
  import chan_event_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              gclr,
  input logic [NCH-1:0]    ev_tc,
  input logic [NCH-1:0]    ev_err,
  input logic [NCH-1:0]    ev_abt,
  input logic [NCH-1:0]    tc_sts,
  input logic [NCH-1:0]    half_sts,
  input logic [NCH-1:0]    err_sts,
  input logic [NCH-1:0]    abt_sts,
  input logic [NCH-1:0]    ch_enable,
  input logic [NCH-1:0]    abort_req,
  input logic              irq
);
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err != '0 && !gclr) |=> ((err_sts & $past(ev_err)) == $past(ev_err)));

  assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gclr |=> ((tc_sts & ~$past(tc_sts) & ~$past(ev_tc)) == '0));

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_sts == '0 && half_sts == '0 && err_sts == '0 && abt_sts == '0) |-> !irq);

  assert_abort_from_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_req != '0) |-> ($past(reg_we) && $past(reg_addr) == OFF_ABORT));

  assert_run_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_err | ev_abt) != '0) |=> ((ch_enable & $past(ev_err | ev_abt)) == '0));

  assert_global_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gclr |=> (ch_enable == '0 && tc_sts == '0 && err_sts == '0 && abt_sts == '0));
endmodule

bind chan_event_ctl chan_event_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_we(reg_we), .reg_addr(reg_addr), .gclr(gclr),
  .ev_tc(ev_tc), .ev_err(ev_err), .ev_abt(ev_abt),
  .tc_sts(tc_sts), .half_sts(half_sts), .err_sts(err_sts), .abt_sts(abt_sts),
  .ch_enable(ch_enable), .abort_req(abort_req), .irq(irq));

// File: tb/sim_chan_event_ctl.sv
module sim_chan_event_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  ev_tc = '0, ev_half = '0, ev_err = '0, ev_abt = '0;
  logic [3:0]  ch_enable, abort_req;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_event_ctl #(.NCH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_tc(ev_tc), .ev_half(ev_half),
    .ev_err(ev_err), .ev_abt(ev_abt), .ch_enable(ch_enable), .abort_req(abort_req),
    .irq(irq));

  // event type order in the sweep: 0 completion, 1 halfway, 2 error, 3 abort
  logic [7:0] stat_off [4] = '{8'h0C, 8'h10, 8'h14, 8'h18};
  int         flag_val [4] = '{8, 16, 2, 4};
  int         inh_pos  [4] = '{4, 5, 2, 3};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [3:0] tc, input logic [3:0] hf,
                      input logic [3:0] er, input logic [3:0] ab);
    reg_we = we; reg_addr = a; reg_wdata = d;
    ev_tc = tc; ev_half = hf; ev_err = er; ev_abt = ab;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
    ev_tc = '0; ev_half = '0; ev_err = '0; ev_abt = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, a, d, 4'h0, 4'h0, 4'h0, 4'h0);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input int t, input logic [3:0] v);
    step(1'b0, 8'h00, '0, (t == 0) ? v : 4'h0, (t == 1) ? v : 4'h0,
         (t == 2) ? v : 4'h0, (t == 3) ? v : 4'h0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int t = 0; t < 4; t++) begin
      rd(stat_off[t], d); chk("R1 status", d, 0);
    end
    rd(8'h04, d); chk("R1 run vector", d, 0);
    for (int c = 0; c < 4; c++) begin
      rd(8'h40 + 8'(4 * c), d); chk("R1 channel control", d, 0);
      rd(8'h80 + 8'(4 * c), d); chk("R6 busy after reset", d, 1);
    end
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 abort_req", {28'd0, abort_req}, 0);

    // sweep every event type on every channel
    for (int t = 0; t < 4; t++) begin
      for (int c = 0; c < 4; c++) begin
        logic [3:0] bitc;
        bitc = 4'(1 << c);
        pulse(t, bitc);
        rd(stat_off[t], d); chk("R2 status bit set", d, 32'(bitc));
        rd(8'h80 + 8'(4 * c), d); chk("R6 summary flag", d, 32'(flag_val[t]));
        chk("R5 irq raised", {31'd0, irq}, 1);
        wr(8'h40 + 8'(4 * c), 32'(1 << inh_pos[t]));
        chk("R5 irq inhibited", {31'd0, irq}, 0);
        rd(stat_off[t], d); chk("R5 status kept while inhibited", d, 32'(bitc));
        wr(8'h40 + 8'(4 * c), 32'd0);
        chk("R5 irq after uninhibit", {31'd0, irq}, 1);
        wr(stat_off[t], 32'(~bitc & 4'hF));
        rd(stat_off[t], d); chk("R3 zero bits keep", d, 32'(bitc));
        wr(stat_off[t], 32'(bitc));
        rd(stat_off[t], d); chk("R3 one clears", d, 0);
        rd(8'h80 + 8'(4 * c), d); chk("R6 busy again", d, 1);
        chk("R5 irq low", {31'd0, irq}, 0);
      end
    end

    // R6 combined flags: error and halfway on channel 1
    step(1'b0, 8'h00, '0, 4'h0, 4'h2, 4'h2, 4'h0);
    rd(8'h81 + 8'h03, d); chk("R6 combined flags", d, 18);
    wr(8'h14, 32'hF); wr(8'h10, 32'hF);

    // R4 event and clear on the same bit; neighbour bit clears
    pulse(0, 4'h2);
    step(1'b1, 8'h0C, 32'h6, 4'h4, 4'h0, 4'h0, 4'h0);
    rd(8'h0C, d); chk("R4 event beats clear", d, 32'h4);
    step(1'b1, 8'h0C, 32'h4, 4'h4, 4'h0, 4'h0, 4'h0);
    rd(8'h0C, d); chk("R4 same bit stays set", d, 32'h4);
    wr(8'h0C, 32'hF);

    // R8 run bits and self clearing
    wr(8'h40, 32'h1); wr(8'h44, 32'h3); wr(8'h48, 32'h1); wr(8'h4C, 32'h1);
    rd(8'h04, d); chk("R8 run vector", d, 32'hF);
    chk("R8 ch_enable port", {28'd0, ch_enable}, 32'hF);
    step(1'b0, 8'h00, '0, 4'h3, 4'h0, 4'h4, 4'h8);
    rd(8'h04, d); chk("R8 stop on tc/err/abort, repeat keeps", d, 32'h2);
    step(1'b1, 8'h40, 32'h1, 4'h0, 4'h0, 4'h1, 4'h0);
    rd(8'h04, d); chk("R8 event wins over write", d, 32'h2);
    rd(8'h44, d); chk("R8 repeat bit readback", d, 32'h3);
    wr(8'h0C, 32'hF); wr(8'h14, 32'hF); wr(8'h18, 32'hF);

    // R7 abort request pulse
    wr(8'h08, 32'hA);
    chk("R7 abort pulse", {28'd0, abort_req}, 32'hA);
    rd(8'h08, d); chk("R7 abort reads zero", d, 0);
    step(1'b0, 8'h00, '0, 4'h0, 4'h0, 4'h0, 4'h0);
    chk("R7 pulse one cycle", {28'd0, abort_req}, 0);

    // R9 global clear against simultaneous events
    wr(8'h40, 32'h5); wr(8'h48, 32'h1);
    pulse(1, 4'h5);
    step(1'b1, 8'h00, 32'h1, 4'h8, 4'h2, 4'h0, 4'h0);
    rd(8'h04, d); chk("R9 run bits cleared", d, 0);
    rd(8'h0C, d); chk("R9 completion cleared", d, 0);
    rd(8'h10, d); chk("R9 halfway cleared", d, 0);
    rd(8'h40, d); chk("R9 inhibit kept", d, 32'h4);
    rd(8'h44, d); chk("R9 repeat kept", d, 32'h2);
    chk("R9 irq low", {31'd0, irq}, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule